// File: doc/BRIEF.md
# Lockable Boot Region Guard for Flash Banks

This block watches a guarded window at the bottom of each flash bank. The window starts at the bank base. The first bank's base is the start of main flash, 0x0800_0000. Each further bank's base is one bank size above the one before it. The window is a whole number of pages long, and software chooses that number through an 8-bit size register per bank. Every access (instruction fetch, data read, program or erase) presents its byte address once. The guard answers in the same cycle, either passing the access on or flagging a bus error. Because every access kind gets the same treatment, there is no input for the access kind.

Each bank also has a lock bit. Software can set it but never clear it, and only a system reset clears it. While a bank's lock is clear, its window is ordinary flash. Once the lock is set, every access inside that window is refused. The size registers accept writes only while the readout-protection level is 0. When the level falls from 1 to 0, the guard sends the flash controller a one-cycle wipe request for every bank whose window is not empty. The controller erases that window even where proprietary-code protection covers it.

Top module: `secreg_guard`

## Requirements
- R1: After reset every size register reads 0, every lock bit reads 0, wipe_o is 0 and no access is refused.
- R2: A size write while prot_lvl_i is 0 (level 0) appears on that bank's slice of size_o (bank b at bits b*8 upward) on the clock after the write.
- R3: A size write while prot_lvl_i is 1, 2 or 3 leaves size_o unchanged.
- R4: A lock write sets the lock bit of each bank whose lock_wdata_i bit is 1. Zero bits do nothing, and a set lock bit stays set until reset.
- R5: A bank whose lock bit is clear never causes a refusal, whatever its size.
- R6: With bank b locked, an access is refused exactly when its address lies in [base_b, base_b + size_b * page bytes), where base_b = FLASH_BASE + b * bank bytes.
- R7: A locked bank whose size is 0 refuses nothing.
- R8: Each bank's lock guards only that bank's window. Locking one bank leaves the other bank's window open.
- R9: When prot_lvl_i goes from 1 to 0, wipe_o has a 1 for each bank with a nonzero size for exactly one cycle, starting on the clock after the change. Other level changes never raise wipe_o.
- R10: When acc_valid_i is high, exactly one of acc_ok_o and acc_err_o is high. When it is low, both are low.
- R11: A window never reaches past its own bank. If the size is larger than the number of pages in a bank, the window ends at the bank end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| prot_lvl_i | input | 2 | Current readout-protection level (0 open, 1 read-protected, 2 and 3 hardened) |
| size_we_i | input | NUM_BANKS | Per-bank size write strobe |
| size_wdata_i | input | SIZE_W | Size value in pages |
| lock_we_i | input | 1 | Lock write strobe |
| lock_wdata_i | input | NUM_BANKS | Lock write data, where a 1 sets that bank's lock |
| size_o | output | NUM_BANKS*SIZE_W | Current window sizes, bank b at bits b*SIZE_W upward |
| lock_o | output | NUM_BANKS | Current lock bits |
| acc_valid_i | input | 1 | Access present |
| acc_addr_i | input | ADDR_W | Access byte address |
| acc_ok_o | output | 1 | Access forwarded to flash |
| acc_err_o | output | 1 | Access refused with a bus error |
| wipe_o | output | NUM_BANKS | Per-bank window erase request |

## Verification
The bench builds the guard with two banks, 2 KiB pages and BANK_LOG2 = 14, which makes each bank only eight pages long. With banks this small, randomly drawn addresses land often below flash, inside both windows, between and past the windows, and beyond the second bank. A size of 12 then runs off the bank end, so the clamping in R11 gets tested. With two banks, the tests can also show that one bank's lock leaves the other bank open and that the wipe request goes only to banks with a nonzero size.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam int unsigned SZ_W = 8;
  localparam logic [31:0] MAIN_BASE = 32'h0800_0000;
  localparam logic [1:0]  LVL_OPEN = 2'd0;
  localparam logic [1:0]  LVL_READ = 2'd1;
endpackage

// File: rtl/secreg_bank_cfg.sv
module secreg_bank_cfg #(
  parameter int unsigned SIZE_W = secreg_pkg::SZ_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_open_i,
  input  logic              size_we_i,
  input  logic [SIZE_W-1:0] size_wdata_i,
  input  logic              lock_set_i,
  output logic [SIZE_W-1:0] size_o,
  output logic              lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_o <= '0;
      lock_o <= 1'b0;
    end else begin
      if (size_we_i && prot_open_i) size_o <= size_wdata_i;
      if (lock_set_i) lock_o <= 1'b1;  // set only; reset is the sole clear
    end
  end
endmodule

// File: rtl/secreg_addr_match.sv
module secreg_addr_match #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = secreg_pkg::SZ_W,
  parameter int unsigned PAGE_LOG2 = 11,
  parameter int unsigned BANK_LOG2 = 18,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] page;
  logic              in_bank;

  always_comb begin
    offset  = addr_i - BASE;               // wraps high when below base
    in_bank = (offset >> BANK_LOG2) == '0;
    page    = offset >> PAGE_LOG2;
    hit_o   = in_bank && (page < ADDR_W'(size_i));
  end
endmodule

// File: rtl/secreg_wipe_detect.sv
module secreg_wipe_detect #(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           lvl_i,
  input  logic [NUM_BANKS-1:0] size_nz_i,
  output logic [NUM_BANKS-1:0] wipe_o
);
  import secreg_pkg::*;
  logic [1:0] lvl_q;
  logic       regress;

  assign regress = (lvl_q == LVL_READ) && (lvl_i == LVL_OPEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= LVL_OPEN;
      wipe_o <= '0;
    end else begin
      lvl_q  <= lvl_i;
      wipe_o <= regress ? size_nz_i : '0;
    end
  end
endmodule

// File: rtl/secreg_guard.sv
module secreg_guard #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = secreg_pkg::SZ_W,
  parameter int unsigned PAGE_LOG2 = 11,
  parameter int unsigned BANK_LOG2 = 18,
  parameter logic [ADDR_W-1:0] FLASH_BASE = ADDR_W'(secreg_pkg::MAIN_BASE)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [1:0]                    prot_lvl_i,
  input  logic [NUM_BANKS-1:0]          size_we_i,
  input  logic [SIZE_W-1:0]             size_wdata_i,
  input  logic                          lock_we_i,
  input  logic [NUM_BANKS-1:0]          lock_wdata_i,
  output logic [NUM_BANKS*SIZE_W-1:0]   size_o,
  output logic [NUM_BANKS-1:0]          lock_o,
  input  logic                          acc_valid_i,
  input  logic [ADDR_W-1:0]             acc_addr_i,
  output logic                          acc_ok_o,
  output logic                          acc_err_o,
  output logic [NUM_BANKS-1:0]          wipe_o
);
  import secreg_pkg::*;

  localparam logic [ADDR_W-1:0] BANK_BYTES = ADDR_W'(1) << BANK_LOG2;

  logic                 prot_open;
  logic [NUM_BANKS-1:0] hit;
  logic [NUM_BANKS-1:0] size_nz;
  logic                 blocked;

  assign prot_open = (prot_lvl_i == LVL_OPEN);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] BANK_BASE = FLASH_BASE + ADDR_W'(b) * BANK_BYTES;

    secreg_bank_cfg #(.SIZE_W(SIZE_W)) u_cfg (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .prot_open_i  (prot_open),
      .size_we_i    (size_we_i[b]),
      .size_wdata_i (size_wdata_i),
      .lock_set_i   (lock_we_i && lock_wdata_i[b]),
      .size_o       (size_o[b*SIZE_W +: SIZE_W]),
      .lock_o       (lock_o[b])
    );

    secreg_addr_match #(
      .ADDR_W    (ADDR_W),
      .SIZE_W    (SIZE_W),
      .PAGE_LOG2 (PAGE_LOG2),
      .BANK_LOG2 (BANK_LOG2),
      .BASE      (BANK_BASE)
    ) u_match (
      .addr_i (acc_addr_i),
      .size_i (size_o[b*SIZE_W +: SIZE_W]),
      .hit_o  (hit[b])
    );

    assign size_nz[b] = |size_o[b*SIZE_W +: SIZE_W];
  end

  secreg_wipe_detect #(.NUM_BANKS(NUM_BANKS)) u_wipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (prot_lvl_i),
    .size_nz_i (size_nz),
    .wipe_o    (wipe_o)
  );

  assign blocked   = |(hit & lock_o);
  assign acc_err_o = acc_valid_i && blocked;
  assign acc_ok_o  = acc_valid_i && !blocked;
endmodule

// File: rtl/secreg_guard_chk.sv
module secreg_guard_chk #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned SIZE_W    = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [1:0]                  prot_lvl_i,
  input logic [NUM_BANKS-1:0]        size_we_i,
  input logic [SIZE_W-1:0]           size_wdata_i,
  input logic [NUM_BANKS*SIZE_W-1:0] size_o,
  input logic [NUM_BANKS-1:0]        lock_o,
  input logic                        acc_valid_i,
  input logic                        acc_ok_o,
  input logic                        acc_err_o,
  input logic [NUM_BANKS-1:0]        wipe_o
);
  p_size_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_we_i[0] && prot_lvl_i == 2'd0 |=> size_o[SIZE_W-1:0] == $past(size_wdata_i));

  p_size_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_lvl_i != 2'd0 |=> $stable(size_o));

  p_lock_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o & $past(lock_o)) == $past(lock_o));

  p_open_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o == '0 && acc_valid_i |-> acc_ok_o);

  p_wipe_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_o != '0 |-> $past(prot_lvl_i) == 2'd0 && $past(prot_lvl_i, 2) == 2'd1);

  p_wipe_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_o != '0 |=> wipe_o == '0);

  p_resp_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |-> (acc_ok_o ^ acc_err_o));

  p_resp_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> !acc_ok_o && !acc_err_o);
endmodule

bind secreg_guard secreg_guard_chk #(.NUM_BANKS(NUM_BANKS), .SIZE_W(SIZE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prot_lvl_i   (prot_lvl_i),
  .size_we_i    (size_we_i),
  .size_wdata_i (size_wdata_i),
  .size_o       (size_o),
  .lock_o       (lock_o),
  .acc_valid_i  (acc_valid_i),
  .acc_ok_o     (acc_ok_o),
  .acc_err_o    (acc_err_o),
  .wipe_o       (wipe_o)
);

// File: tb/tb_secreg_guard.sv
module tb_secreg_guard;
  localparam int unsigned NB = 2;
  localparam int unsigned SW = 8;
  localparam int unsigned BL = 14;
  localparam int unsigned PL = 11;
  localparam logic [31:0] FB = 32'h0800_0000;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [1:0]     prot_lvl_i = 2'd0;
  logic [NB-1:0]  size_we_i = '0;
  logic [SW-1:0]  size_wdata_i = '0;
  logic           lock_we_i = 1'b0;
  logic [NB-1:0]  lock_wdata_i = '0;
  logic [NB*SW-1:0] size_o;
  logic [NB-1:0]  lock_o;
  logic           acc_valid_i = 1'b0;
  logic [31:0]    acc_addr_i = '0;
  logic           acc_ok_o, acc_err_o;
  logic [NB-1:0]  wipe_o;

  int checks = 0;
  int fails  = 0;
  int size_m [NB];
  bit lock_m [NB];

  always #4 clk_i = ~clk_i;

  secreg_guard #(.NUM_BANKS(NB), .PAGE_LOG2(PL), .BANK_LOG2(BL)) dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(logic [31:0] a);
    for (int b = 0; b < NB; b++) begin
      logic [31:0] base;
      base = FB + (32'(b) << BL);
      if (lock_m[b] && a >= base && a < base + (32'd1 << BL) &&
          ((a - base) >> PL) < 32'(size_m[b])) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] exp_size();
    logic [31:0] v = '0;
    for (int b = 0; b < NB; b++) v[b*SW +: SW] = SW'(size_m[b]);
    return v;
  endfunction

  function automatic logic [31:0] exp_lock();
    logic [31:0] v = '0;
    for (int b = 0; b < NB; b++) v[b] = lock_m[b];
    return v;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin size_m[b] = 0; lock_m[b] = 0; end
  endtask

  task automatic wr_size(int b, int v);
    @(negedge clk_i);
    size_we_i = '0; size_we_i[b] = 1'b1; size_wdata_i = SW'(v);
    @(negedge clk_i);
    size_we_i = '0;
    if (prot_lvl_i == 2'd0) size_m[b] = v & 8'hFF;
  endtask

  task automatic wr_lock(logic [NB-1:0] m);
    @(negedge clk_i);
    lock_we_i = 1'b1; lock_wdata_i = m;
    @(negedge clk_i);
    lock_we_i = 1'b0;
    for (int b = 0; b < NB; b++) if (m[b]) lock_m[b] = 1'b1;
  endtask

  task automatic probe(string req, logic [31:0] a);
    bit e;
    @(negedge clk_i);
    acc_valid_i = 1'b1; acc_addr_i = a;
    #1;
    e = exp_err(a);
    chk(req, {30'd0, acc_err_o, acc_ok_o}, {30'd0, e, !e});
    acc_valid_i = 1'b0;
  endtask

  // from_lvl then 0; wipe sampled the cycle after the drop, then one cycle later
  task automatic regress(string req, logic [1:0] from_lvl, logic [NB-1:0] exp);
    @(negedge clk_i); prot_lvl_i = from_lvl;
    @(negedge clk_i); prot_lvl_i = 2'd0;
    @(negedge clk_i); chk(req, 32'(wipe_o), 32'(exp));
    @(negedge clk_i); chk(req, 32'(wipe_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 size", 32'(size_o), 32'd0);
    chk("R1 lock", 32'(lock_o), 32'd0);
    chk("R1 wipe", 32'(wipe_o), 32'd0);
    probe("R1 access", FB);

    wr_size(0, 3); chk("R2 bank0", 32'(size_o), exp_size());
    wr_size(1, 5); chk("R2 bank1", 32'(size_o), exp_size());
    for (int i = 0; i < 150; i++)
      probe("R5 unlocked", FB - 32'h1000 + ($urandom % 32'h10000));

    prot_lvl_i = 2'd1; wr_size(0, 9); chk("R3 level1", 32'(size_o), exp_size());
    prot_lvl_i = 2'd2; wr_size(1, 7); chk("R3 level2", 32'(size_o), exp_size());
    prot_lvl_i = 2'd3; wr_size(0, 1); chk("R3 level3", 32'(size_o), exp_size());

    regress("R9 from level2", 2'd2, 2'b00);
    regress("R9 from level1", 2'd1, 2'b11);
    wr_size(1, 0);
    regress("R9 empty bank1", 2'd1, 2'b01);
    wr_size(1, 5);

    wr_lock(2'b00); chk("R4 zero write", 32'(lock_o), 32'd0);
    wr_lock(2'b01); chk("R4 set bank0", 32'(lock_o), exp_lock());
    probe("R6 first byte", FB);
    probe("R6 last byte", FB + 32'h17FF);
    probe("R6 past end", FB + 32'h1800);
    probe("R6 below base", FB - 32'd1);
    probe("R8 bank1 open", FB + 32'h4000);
    wr_lock(2'b00); chk("R4 sticky", 32'(lock_o), exp_lock());

    @(negedge clk_i); acc_valid_i = 1'b0; acc_addr_i = FB; #1;
    chk("R10 idle", {30'd0, acc_err_o, acc_ok_o}, 32'd0);

    wr_size(1, 0); wr_lock(2'b10);
    probe("R7 empty locked", FB + 32'h4000);
    wr_size(1, 12);
    probe("R11 bank end", FB + 32'h7FFF);
    probe("R11 beyond bank", FB + 32'h8000);

    for (int i = 0; i < 300; i++) begin
      if ($urandom % 16 == 0) wr_size($urandom % NB, $urandom % 12);
      probe("R6 random", FB - 32'h1000 + ($urandom % 32'h10000));
    end

    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1; model_reset();
    @(negedge clk_i);
    chk("R4 reset clears lock", 32'(lock_o), 32'd0);
    chk("R1 reset size", 32'(size_o), 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule